// File: doc/BRIEF.md
# Candidate Location Tag Filter

This block sits in a streaming seed-lookup pipeline, between the hash-table read path and the reference fetch. Each input beat is either a hash-bucket entry or an end-of-read fence. An entry carries the tag stored in the bucket and a reference position, together with the key of the seed whose lookup produced it. Several seeds share one bucket, so the block first keeps only entries whose stored tag equals the forwarded seed key.

Surviving positions pass through a small content-addressable set of positions already seen for the current read. A position found there is dropped. A new one is recorded and turned into exactly one reference-read request. A read typically yields tens to hundreds of entries but only a few distinct positions, so the output runs far below the input rate. The number of entries per read is not known in advance, so an in-band fence marks the end of each read. The fence travels out behind every earlier request and empties the seen set as it is accepted.

Both sides use valid/ready handshakes. A single output register holds one item at a time, and the input stalls while that register is full and blocked.

Top module: `cal_tag_filter`

## Requirements
- R1: An entry whose `in_tag` differs from `in_key` is consumed and produces no output.
- R2: A matching entry whose position is already in the seen set for the current read is consumed and produces no output.
- R3: A matching entry with a new position produces one output item with `out_fence`=0 and `out_pos` equal to its position, valid in the cycle after acceptance. Outputs keep input order.
- R4: An accepted fence produces one output item with `out_fence`=1 and `out_pos`=0, after every request from earlier entries.
- R5: The seen set is emptied in the cycle a fence is accepted. An entry accepted in the very next cycle is checked against an empty set, so a position seen before the fence is forwarded again.
- R6: The seen set holds SEEN_DEPTH (default 32) positions. When it is full, a new matching position is still forwarded but not stored, so a later repeat of it is forwarded again. `ovf_flag` is then set and stays at 1 until reset.
- R7: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `out_pos`/`out_fence` hold steady. No item is lost or duplicated under back-pressure.
- R8: After reset, `out_valid`=0, `ovf_flag`=0, `in_ready`=1 and the seen set is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_fence | input | 1 | Beat is an end-of-read fence |
| in_tag | input | TAG_W | Tag stored in the bucket entry |
| in_key | input | TAG_W | Key of the seed that made the lookup |
| in_pos | input | POS_W | Reference position of the entry |
| out_valid | output | 1 | Output item valid |
| out_ready | input | 1 | Downstream accepts the item |
| out_fence | output | 1 | Output item is a fence |
| out_pos | output | POS_W | Position to read from the reference (0 for a fence) |
| ovf_flag | output | 1 | Sticky flag: a unique position did not fit in the seen set |

## Verification
The hardest case to reach from the ports is the saturated set. Only a full set shows that the 33rd distinct position is forwarded but never stored, and that a repeat of it is forwarded a second time while repeats of stored positions are still dropped. The stimulus fills the set with 33 distinct matching positions in one read, then replays the first and the last. A fence followed in the next cycle by an already-seen position covers the clear timing. Random downstream stalls run throughout, and one fixed stall checks that the output holds.

// File: rtl/cal_filter_pkg.sv
package cal_filter_pkg;
  localparam int unsigned TAG_W_DEF      = 16;
  localparam int unsigned POS_W_DEF      = 24;
  localparam int unsigned SEEN_DEPTH_DEF = 32;
endpackage

// File: rtl/seen_pos_cam.sv
module seen_pos_cam #(
  parameter int unsigned POS_W = 24,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ins,
  input  logic [POS_W-1:0] key_pos,
  output logic             hit,
  output logic             full,
  output logic [CNT_W-1:0] fill
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DEPTH-1:0] match_vec;

  assign full = (cnt_q == CNT_W'(DEPTH));
  assign fill = cnt_q;
  assign hit  = |match_vec;

  // Slots fill in order and are only freed all at once, so slot i is live when i < cnt.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [POS_W-1:0] pos_q;
    logic             wr_en;
    assign wr_en        = ins && !full && (cnt_q == CNT_W'(i));
    assign match_vec[i] = (CNT_W'(i) < cnt_q) && (pos_q == key_pos);
    always_ff @(posedge clk) begin
      if (wr_en) pos_q <= key_pos;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                cnt_d = '0;
    else if (ins && !full)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R6
  AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr) |=> full); // R6
endmodule

// File: rtl/filt_out_stage.sv
module filt_out_stage #(
  parameter int unsigned POS_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             ld_fence,
  input  logic [POS_W-1:0] ld_pos,
  input  logic             out_ready,
  output logic             can_take,
  output logic             out_valid,
  output logic             out_fence,
  output logic [POS_W-1:0] out_pos
);
  logic             vld_q, vld_d;
  logic             fen_q, fen_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             data_en;

  assign can_take  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_fence = fen_q;
  assign out_pos   = pos_q;
  assign data_en   = load && can_take;

  always_comb begin
    vld_d = vld_q;
    fen_d = fen_q;
    pos_d = pos_q;
    if (vld_q && out_ready) vld_d = 1'b0;
    if (data_en) begin
      vld_d = 1'b1;
      fen_d = ld_fence;
      pos_d = ld_fence ? '0 : ld_pos;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      fen_q <= 1'b0;
      pos_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (data_en) begin
        fen_q <= fen_d;
        pos_q <= pos_d;
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !out_ready) |=> (vld_q && $stable(pos_q) && $stable(fen_q))); // R7
  AST_FENCE_POS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && fen_q) |-> (pos_q == '0)); // R4
endmodule

// File: rtl/cal_tag_filter.sv
module cal_tag_filter
  import cal_filter_pkg::*;
#(
  parameter int unsigned TAG_W      = TAG_W_DEF,
  parameter int unsigned POS_W      = POS_W_DEF,
  parameter int unsigned SEEN_DEPTH = SEEN_DEPTH_DEF,
  localparam int unsigned CNT_W     = $clog2(SEEN_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_fence,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [TAG_W-1:0] in_key,
  input  logic [POS_W-1:0] in_pos,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_fence,
  output logic [POS_W-1:0] out_pos,
  output logic             ovf_flag
);
  logic             accept, tag_ok, seen_hit, seen_full;
  logic             new_pos, fwd, fence_acc;
  logic [CNT_W-1:0] seen_fill;
  logic             ovf_q, ovf_d;

  assign accept    = in_valid && in_ready;
  assign fence_acc = accept && in_fence;
  assign tag_ok    = (in_tag == in_key);
  assign new_pos   = accept && !in_fence && tag_ok && !seen_hit;
  assign fwd       = fence_acc || new_pos;

  seen_pos_cam #(.POS_W(POS_W), .DEPTH(SEEN_DEPTH)) u_seen (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (fence_acc),
    .ins     (new_pos),
    .key_pos (in_pos),
    .hit     (seen_hit),
    .full    (seen_full),
    .fill    (seen_fill)
  );

  filt_out_stage #(.POS_W(POS_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fwd),
    .ld_fence  (in_fence),
    .ld_pos    (in_pos),
    .out_ready (out_ready),
    .can_take  (in_ready),
    .out_valid (out_valid),
    .out_fence (out_fence),
    .out_pos   (out_pos)
  );

  always_comb begin
    ovf_d = ovf_q;
    if (new_pos && seen_full) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign ovf_flag = ovf_q;

  AST_TAG_MISS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_fence && !tag_ok) |=> !out_valid); // R1
  AST_DUP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_fence && seen_hit) |=> !out_valid); // R2
  AST_NEW_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    new_pos |=> (out_valid && !out_fence && out_pos == $past(in_pos))); // R3
  AST_FENCE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    fence_acc |=> (seen_fill == '0 && out_valid && out_fence)); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q); // R6
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R7
endmodule

// File: tb/cal_tag_filter_bench.sv
module cal_tag_filter_bench;
  localparam int TAG_W = 16;
  localparam int POS_W = 24;
  localparam int DEPTH = 32;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_fence = 1'b0, out_ready = 1'b1;
  logic [TAG_W-1:0] in_tag = '0, in_key = '0;
  logic [POS_W-1:0] in_pos = '0;
  logic in_ready, out_valid, out_fence, ovf_flag;
  logic [POS_W-1:0] out_pos;

  int errors = 0, checks = 0, cycles = 0;
  int rdy_mode = 0;       // 0 always ready, 1 random, 2 stalled
  logic [POS_W:0] exp_q[$];
  logic [POS_W-1:0] seen[$];
  logic exp_ovf = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_tag_filter u_cal_tag_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_fence(in_fence), .in_tag(in_tag), .in_key(in_key), .in_pos(in_pos),
    .out_valid(out_valid), .out_ready(out_ready), .out_fence(out_fence),
    .out_pos(out_pos), .ovf_flag(ovf_flag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Ready generator, updated just after each rising edge.
  initial forever begin
    @(posedge clk); #1;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = ($urandom_range(0, 2) != 0);
      default: out_ready = 1'b0;
    endcase
  end

  // Monitor: compares each handshaken output item with the scoreboard.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1/R2", "unexpected output", {out_fence, out_pos}, 0);
      end else begin
        logic [POS_W:0] e;
        e = exp_q.pop_front();
        check({out_fence, out_pos} == e, e[POS_W] ? "R4" : "R3",
              "output item {fence,pos}", {out_fence, out_pos}, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      finish_run();
    end
  end

  task automatic xfer(input bit f, input logic [TAG_W-1:0] t,
                      input logic [TAG_W-1:0] k, input logic [POS_W-1:0] p);
    @(negedge clk);
    in_valid = 1'b1; in_fence = f; in_tag = t; in_key = k; in_pos = p;
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // Driver with reference model: pushes expected items into the scoreboard.
  task automatic send(input logic [TAG_W-1:0] t, input logic [TAG_W-1:0] k,
                      input logic [POS_W-1:0] p);
    if (t == k) begin
      bit found = 1'b0;
      foreach (seen[i]) if (seen[i] == p) found = 1'b1;
      if (!found) begin
        exp_q.push_back({1'b0, p});
        if (seen.size() < DEPTH) seen.push_back(p);
        else exp_ovf = 1'b1;
      end
    end
    xfer(1'b0, t, k, p);
  endtask

  task automatic fence();
    exp_q.push_back({1'b1, {POS_W{1'b0}}});
    seen.delete();
    xfer(1'b1, '0, '0, '0);
  endtask

  task automatic drain(input string req);
    for (int n = 0; n < 2000 && (exp_q.size() != 0 || out_valid); n++) @(negedge clk);
    check(exp_q.size() == 0, req, "items left in scoreboard", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
    check(ovf_flag == 1'b0, "R8", "ovf_flag after reset", ovf_flag, 0);
    check(in_ready == 1'b1, "R8", "in_ready after reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: tag mismatches dropped, matches passed
    send(16'h0011, 16'h0022, 24'h000100);
    send(16'h0033, 16'h0033, 24'h000200);
    send(16'h0034, 16'h0033, 24'h000300);
    send(16'h0044, 16'h0044, 24'h000400);
    drain("R1");

    // R2: duplicates in the same read dropped, mixed with mismatches
    send(16'h0001, 16'h0001, 24'h000200);
    send(16'h0002, 16'h0002, 24'h000500);
    send(16'h0003, 16'h0003, 24'h000400);
    send(16'h0009, 16'h0008, 24'h000600);
    send(16'h0008, 16'h0008, 24'h000600);
    send(16'h0005, 16'h0005, 24'h000500);
    drain("R2");

    // R4 and R5: fence, then the very next cycle a previously seen position
    fence();
    send(16'h0007, 16'h0007, 24'h000200);
    send(16'h0007, 16'h0007, 24'h000200);
    drain("R5");
    check(ovf_flag == 1'b0, "R6", "ovf_flag before fill", ovf_flag, 0);
    fence();

    // R6: saturate the seen set
    for (int i = 0; i < DEPTH + 1; i++) send(16'h00AA, 16'h00AA, 24'h010000 + 24'(i));
    send(16'h00AA, 16'h00AA, 24'h010000 + 24'(DEPTH));
    send(16'h00AA, 16'h00AA, 24'h010000);
    drain("R6");
    @(negedge clk);
    check(ovf_flag == exp_ovf, "R6", "ovf_flag after overflow", ovf_flag, exp_ovf);
    fence();
    drain("R6");
    check(ovf_flag == 1'b1, "R6", "ovf_flag sticky across fence", ovf_flag, 1);

    // R7: fixed stall, output must hold and input must stall
    rdy_mode = 2;
    @(posedge clk); #2;
    send(16'h0010, 16'h0010, 24'h00ABCD);
    fork
      send(16'h0010, 16'h0010, 24'h00BEEF);
      begin
        repeat (3) @(negedge clk);
        check(in_ready == 1'b0, "R7", "in_ready while stalled", in_ready, 0);
        check(out_valid && out_pos == 24'h00ABCD, "R7", "held out_pos",
              out_pos, 24'h00ABCD);
        rdy_mode = 0;
      end
    join
    drain("R7");

    // R7: random back-pressure over several reads
    rdy_mode = 1;
    for (int r = 0; r < 6; r++) begin
      for (int j = 0; j < 40; j++) begin
        logic [TAG_W-1:0] k;
        k = 16'(r);
        send(($urandom_range(0, 3) == 0) ? k + 16'h1 : k, k,
             24'($urandom_range(0, 7)) + 24'(r * 8));
      end
      fence();
    end
    drain("R7");
    rdy_mode = 0;

    finish_run();
  end
endmodule